// File: doc/BRIEF.md
# Margining Divider Serial Loader

This block sits beside the feedback path of a clock synthesizer whose output can be nudged up or down in 2% steps. A three-wire serial port (serial clock, serial data, load strobe) shifts a 6-bit feedback divider word into the block. The word moves into a holding register when the strobe drops. A mode input picks what the PLL is given. When low, it gets a hard nominal divider of 50. When high, it gets the held programmed word.

All three serial wires and the mode input come from slow pins. The block samples them into its own faster system clock through two-flop synchronizers, and it detects edges in that domain. From the effective divider M it also derives the VCO frequency (12·M MHz, from a 12 MHz reference) and the synthesized output frequency (2·M MHz, after a fixed divide by 6). It raises a flag when the VCO sits in its lockable 540..680 MHz band.

Top module: `margin_div_loader`

## Requirements
- R1: After reset the held word is 50, so with mode high and nothing loaded the effective divider is 50.
- R2: While the strobe is high, each rising serial clock edge shifts in one data bit, most significant bit first. A falling strobe copies the 6-bit shift register into the held word.
- R3: While the strobe is low, serial clock and data activity leaves the shift register unchanged. A later strobe pulse with no clocks therefore re-commits the old contents.
- R4: With mode low the effective divider is 50 (binary 110010), whatever word is held.
- R5: Leaving margining mode gives 50 again. Returning to margining mode restores the held word, which is kept across mode changes.
- R6: A load performed while mode is low updates the held word without changing the effective divider.
- R7: The VCO frequency output equals 12 times the effective divider, in MHz (10 bits).
- R8: The output frequency output equals 2 times the effective divider, in MHz (7 bits).
- R9: The valid flag is high exactly when the effective divider is between 45 and 56 inclusive.
- R10: When more than six bits are shifted during one strobe, the last six received are committed.
- R11: The effective divider changes only after a strobe fall or a mode change, never while bits are being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data, sampled on serial clock rise |
| ser_ld | input | 1 | Load strobe; high enables shifting, fall commits |
| margin_en | input | 1 | 0 = nominal divider, 1 = programmed divider |
| div_word | output | 6 | Effective feedback divider |
| div_ok | output | 1 | Effective divider is within the lockable range |
| vco_mhz | output | 10 | VCO frequency in MHz |
| out_mhz | output | 7 | Output frequency in MHz |

## Verification
A pin change on the serial clock or strobe passes two synchronizer flops and one edge-detect flop. The resulting shift or commit is therefore visible on the outputs after the third rising system clock edge. A mode change shows after the second. The bench holds every serial level for four system cycles and waits at least six cycles after the last pin change before it queues an expectation. The monitor compares on the next falling edge, so every result is sampled well after it is due and well before the next stimulus. For the mid-frame check, the sample is taken after all six bits have been shifted and before the strobe drops.

// File: rtl/margin_div_loader.sv
module margin_div_loader #(
  parameter int DW      = 6,
  parameter int NOMINAL = 50,
  parameter int REF_MHZ = 12,
  parameter int OUT_DIV = 6,
  parameter int VCO_MIN = 540,
  parameter int VCO_MAX = 680,
  parameter int VW      = $clog2((2**DW - 1) * REF_MHZ + 1),
  parameter int OW      = $clog2((2**DW - 1) * (REF_MHZ / OUT_DIV) + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_clk,
  input  logic          ser_dat,
  input  logic          ser_ld,
  input  logic          margin_en,
  output logic [DW-1:0] div_word,
  output logic          div_ok,
  output logic [VW-1:0] vco_mhz,
  output logic [OW-1:0] out_mhz
);
  localparam int STEP = REF_MHZ / OUT_DIV;
  localparam logic [DW-1:0] NOM_W = DW'(NOMINAL);

  logic [3:0] meta_q, sync_q;
  logic       sclk_d, ld_d;
  logic [DW-1:0] shreg, prog;

  wire sclk_s = sync_q[0];
  wire dat_s  = sync_q[1];
  wire ld_s   = sync_q[2];
  wire mode_s = sync_q[3];
  wire sclk_rise = sclk_s & ~sclk_d;
  wire ld_fall   = ~ld_s & ld_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      sclk_d <= 1'b0;
      ld_d   <= 1'b0;
    end else begin
      meta_q <= {margin_en, ser_ld, ser_dat, ser_clk};
      sync_q <= meta_q;
      sclk_d <= sclk_s;
      ld_d   <= ld_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                shreg <= '0;
    else if (ld_s && sclk_rise) shreg <= {shreg[DW-2:0], dat_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prog <= NOM_W;
    else if (ld_fall) prog <= shreg;
  end

  assign div_word = mode_s ? prog : NOM_W;
  assign vco_mhz  = VW'(div_word * REF_MHZ);
  assign out_mhz  = OW'(div_word * STEP);
  assign div_ok   = (vco_mhz >= VW'(VCO_MIN)) && (vco_mhz <= VW'(VCO_MAX));

  assert_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fall |=> (prog == $past(shreg)));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_s |=> $stable(shreg));

  assert_leave_nominal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_s) |-> (div_word == NOM_W));

  assert_out_ratio_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(out_mhz) * OUT_DIV) == 32'(vco_mhz));

  assert_change_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_word) |-> ($past(ld_fall) || !$stable(mode_s)));
endmodule

// File: tb/margin_div_loader_tb_top.sv
module margin_div_loader_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0, margin_en = 1'b0;
  logic [5:0] div_word;
  logic       div_ok;
  logic [9:0] vco_mhz;
  logic [6:0] out_mhz;

  always #2 clk = ~clk;

  margin_div_loader dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_ld(ser_ld), .margin_en(margin_en), .div_word(div_word),
    .div_ok(div_ok), .vco_mhz(vco_mhz), .out_mhz(out_mhz));

  typedef struct {
    string tag;
    int    d;
    int    v;
    int    o;
    bit    ok;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_bad = 0;
  int held = 50;
  bit mode = 1'b0;
  bit done = 1'b0;

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(string tag);
    item_t it;
    int d;
    d = mode ? held : 50;
    it.tag = tag; it.d = d; it.v = 12 * d; it.o = 2 * d;
    it.ok = (d >= 45) && (d <= 56);
    q.push_back(it);
    wait (q.size() == 0);
    wait_cyc(1);
  endtask

  task automatic shift_bits(int n, logic [15:0] val);
    ser_ld = 1'b1;
    wait_cyc(4);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = val[i];
      wait_cyc(4);
      ser_clk = 1'b1;
      wait_cyc(4);
      ser_clk = 1'b0;
      wait_cyc(2);
    end
    wait_cyc(4);
  endtask

  task automatic drop_ld(int committed);
    ser_ld = 1'b0;
    held = committed;
    wait_cyc(6);
  endtask

  task automatic load(int val);
    shift_bits(6, 16'(val));
    drop_ld(val & 63);
  endtask

  task automatic set_mode(bit m);
    margin_en = m;
    mode = m;
    wait_cyc(6);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      n_chk++;
      if (int'(div_word) != e.d || int'(vco_mhz) != e.v || int'(out_mhz) != e.o || div_ok != e.ok) begin
        n_bad++;
        $display("FAIL %s: got div=%0d vco=%0d out=%0d ok=%0b, expected div=%0d vco=%0d out=%0d ok=%0b",
                 e.tag, div_word, vco_mhz, out_mhz, div_ok, e.d, e.v, e.o, e.ok);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(4);
    expect_now("R1/R4 reset nominal");
    set_mode(1'b1);
    expect_now("R1 reset held word");
    load(52);
    expect_now("R2/R7/R8 load 52");
    load(44);
    expect_now("R9 below range 44");
    shift_bits(6, 16'd45);
    expect_now("R11 unchanged mid-frame");
    drop_ld(45);
    expect_now("R9 low edge 45");
    load(56);
    expect_now("R9 high edge 56");
    load(57);
    expect_now("R9 above range 57");
    ser_ld = 1'b0;
    for (int i = 0; i < 5; i++) begin
      ser_dat = i[0]; wait_cyc(4); ser_clk = 1'b1; wait_cyc(4); ser_clk = 1'b0; wait_cyc(2);
    end
    wait_cyc(4);
    expect_now("R3 clocks with strobe low");
    ser_ld = 1'b1; wait_cyc(6);
    drop_ld(57);
    expect_now("R3 shift register kept");
    shift_bits(9, 16'b101_110111);
    drop_ld(55);
    expect_now("R10 last six bits");
    set_mode(1'b0);
    expect_now("R4/R5 back to nominal");
    load(47);
    expect_now("R6 load in nominal hidden");
    set_mode(1'b1);
    expect_now("R5/R6 held word restored");
    set_mode(1'b0);
    expect_now("R5 leave again");
    set_mode(1'b1);
    load(0);
    expect_now("R7/R9 zero word");
    load(63);
    expect_now("R7/R8 max word");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule